// File: doc/BRIEF.md
# AC'97 Codec Register Access Unit

This block lets a host read and write the control registers of an external AC'97 codec. Software loads a command through a small register bus: the command-data word first, then the command-address word, which arms the command. At the next frame boundary the engine places both words into the command-address and command-data slots of the outgoing frame. On the return path it captures the slots the codec sends back, flags them as valid, and offers a result register that checks the echoed address against the last read request.

A parallel slot interface stands in for the serial link. An internal timer gives a one-cycle frame strobe every `FRAME_LEN` clocks. Each slot has its own transmit-busy and receive-valid flags. Per-slot transmit and receive enables and a codec-select field in the control word gate all slot traffic. A load into a transmit register that is still busy is dropped and raises a sticky error.

Register map (3-bit offset, 20-bit data):
- 0 control: bit0 slot1 tx enable, bit1 slot2 tx enable, bit2 slot1 rx enable, bit3 slot2 rx enable, bits5:4 codec select.
- 1 slot1 transmit.
- 2 slot2 transmit.
- 3 slot1 receive (read clears its valid flag).
- 4 slot2 receive (read clears its valid flag).
- 5 status: bit0 slot1 busy, bit1 slot2 busy, bit2 slot1 valid, bit3 slot2 valid, bit4 error (write 1 to clear).
- 6 read result.

Top module: `ac97_cmd_port`

## Requirements
- R1: After reset the status, control and both transmit registers read as zero, and `tx_frame_o`, `tx_sl1_vld_o` and `tx_sl2_vld_o` are low.
- R2: `tx_frame_o` pulses for one cycle every `FRAME_LEN` clocks. Slot valid outputs are high only during that pulse.
- R3: A slot1 word has its read flag at bit 19 (1 = read, 0 = write) and the codec register address at bits 18:12. A slot2 word has its data at bits 19:4. A write loaded as slot2 then slot1 sends both words unchanged in the same frame. Slot2 is never sent without slot1.
- R4: Each slot's busy flag (status bit0 or bit1) sets when a load is accepted and clears in the frame that sends that slot.
- R5: A slot1 load that lands in the same cycle as a frame boundary is not sent in that frame; it goes out in the following frame.
- R6: A load into a transmit register whose busy flag is set leaves the register unchanged and sets status bit4. That bit stays set until a write of 1 to status bit4 clears it.
- R7: While a slot's transmit enable is clear, that slot is not sent and stays busy. It goes out in the first frame after the enable is set.
- R8: An incoming frame whose codec id matches the codec select and that carries an enabled slot stores the word and sets that slot's valid flag (status bit2 or bit3). Reading the receive register returns the word and clears only that slot's flag. A capture in the same cycle as the read leaves the flag set with the new word.
- R9: An incoming slot whose receive enable is clear, or a frame whose codec id differs from the select field, is not captured: the valid flag and the stored word stay unchanged.
- R10: The result register returns slot2 bits 19:4 when the captured slot1 address equals the address of the last read request loaded. Otherwise it returns 16'hFFFF. Reading it clears both valid flags.
- R11: `tx_codec_o` carries the codec select field during each frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register offset |
| bus_wdata_i | input | 20 | Write data |
| bus_rdata_o | output | 20 | Read data (combinational) |
| tx_frame_o | output | 1 | Outgoing frame strobe |
| tx_codec_o | output | 2 | Codec targeted by this frame |
| tx_sl1_vld_o | output | 1 | Slot1 present in this frame |
| tx_sl1_o | output | 20 | Outgoing command-address slot |
| tx_sl2_vld_o | output | 1 | Slot2 present in this frame |
| tx_sl2_o | output | 20 | Outgoing command-data slot |
| rx_frame_i | input | 1 | Incoming frame strobe |
| rx_codec_i | input | 2 | Codec that sent the incoming frame |
| rx_sl1_vld_i | input | 1 | Incoming slot1 present |
| rx_slot1_i | input | 20 | Incoming status-address slot |
| rx_sl2_vld_i | input | 1 | Incoming slot2 present |
| rx_slot2_i | input | 20 | Incoming status-data slot |

## Verification
Two pairs of events can fall in the same cycle. The first is a software load of the slot1 transmit register and the frame boundary. The bench counts cycles from an observed frame pulse so that the load lands exactly on the boundary edge. It then checks that this frame carries no slot1 and the next one does. The second is a read of a receive register and a capture of the same slot. The bench drives both in one cycle and checks that the read returns the old word while the valid flag stays set with the new word.

// File: rtl/ac97_cmd_pkg.sv
package ac97_cmd_pkg;
  localparam int SLOT_W  = 20;
  localparam int CADDR_W = 7;
  localparam int CDATA_W = 16;
  localparam int CODEC_W = 2;
  localparam int BADDR_W = 3;
  localparam int RDFLAG_BIT = SLOT_W - 1;
  localparam int CADDR_LSB  = 12;
  localparam int CDATA_LSB  = 4;

  typedef enum logic [BADDR_W-1:0] {
    RA_CTRL = 3'd0,
    RA_TX1  = 3'd1,
    RA_TX2  = 3'd2,
    RA_RX1  = 3'd3,
    RA_RX2  = 3'd4,
    RA_STAT = 3'd5,
    RA_RES  = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic [CODEC_W-1:0] codec;
    logic               rx2_en;
    logic               rx1_en;
    logic               tx2_en;
    logic               tx1_en;
  } ctrl_t;
endpackage

// File: rtl/ac97_frame_timer.sv
module ac97_frame_timer #(
  parameter int FRAME_LEN = 256
) (
  input  logic clk,
  input  logic rst_n,
  output logic fire_o
);
  localparam int CNT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (cnt_q == LAST) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fire_o = (cnt_q == LAST);

  // R2: boundary is followed by a restart of the count
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (cnt_q == '0));
endmodule

// File: rtl/ac97_cmd_tx.sv
module ac97_cmd_tx
  import ac97_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  ctrl_t             ctrl_i,
  input  logic              wr_tx1_i,
  input  logic              wr_tx2_i,
  input  logic [SLOT_W-1:0] wdata_i,
  output logic              tx1_busy_o,
  output logic              tx2_busy_o,
  output logic [SLOT_W-1:0] tx1_word_o,
  output logic [SLOT_W-1:0] tx2_word_o,
  output logic              drop_o,
  output logic              rd_load_o,
  output logic [CADDR_W-1:0] rd_addr_o,
  output logic              tx_frame_o,
  output logic [CODEC_W-1:0] tx_codec_o,
  output logic              tx_sl1_vld_o,
  output logic [SLOT_W-1:0] tx_sl1_o,
  output logic              tx_sl2_vld_o,
  output logic [SLOT_W-1:0] tx_sl2_o
);
  logic [SLOT_W-1:0] tx1_q, tx1_d, tx2_q, tx2_d;
  logic              b1_q, b1_d, b2_q, b2_d;
  logic              acc1, acc2, send1, send2;
  logic              frm_q, v1_q, v2_q;
  logic [SLOT_W-1:0] o1_q, o1_d, o2_q, o2_d;
  logic [CODEC_W-1:0] cod_q;

  always_comb begin
    acc1  = wr_tx1_i && !b1_q;
    acc2  = wr_tx2_i && !b2_q;
    send1 = fire_i && b1_q && ctrl_i.tx1_en;
    send2 = send1 && b2_q && ctrl_i.tx2_en;
    tx1_d = acc1 ? wdata_i : tx1_q;
    tx2_d = acc2 ? wdata_i : tx2_q;
    b1_d  = b1_q;
    b2_d  = b2_q;
    if (send1) b1_d = 1'b0;
    if (send2) b2_d = 1'b0;
    if (acc1)  b1_d = 1'b1;
    if (acc2)  b2_d = 1'b1;
    o1_d  = send1 ? tx1_q : '0;
    o2_d  = send2 ? tx2_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx1_q <= '0;
      tx2_q <= '0;
      b1_q  <= 1'b0;
      b2_q  <= 1'b0;
    end else begin
      tx1_q <= tx1_d;
      tx2_q <= tx2_d;
      b1_q  <= b1_d;
      b2_q  <= b2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q <= 1'b0;
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
      o1_q  <= '0;
      o2_q  <= '0;
      cod_q <= '0;
    end else begin
      frm_q <= fire_i;
      v1_q  <= send1;
      v2_q  <= send2;
      if (fire_i) begin
        o1_q  <= o1_d;
        o2_q  <= o2_d;
        cod_q <= ctrl_i.codec;
      end
    end
  end

  assign tx1_busy_o   = b1_q;
  assign tx2_busy_o   = b2_q;
  assign tx1_word_o   = tx1_q;
  assign tx2_word_o   = tx2_q;
  assign drop_o       = (wr_tx1_i && b1_q) || (wr_tx2_i && b2_q);
  assign rd_load_o    = acc1 && wdata_i[RDFLAG_BIT];
  assign rd_addr_o    = wdata_i[CADDR_LSB +: CADDR_W];
  assign tx_frame_o   = frm_q;
  assign tx_codec_o   = cod_q;
  assign tx_sl1_vld_o = v1_q;
  assign tx_sl1_o     = o1_q;
  assign tx_sl2_vld_o = v2_q;
  assign tx_sl2_o     = o2_q;

  p_ignore_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx1_i && b1_q) |=> $stable(tx1_q));
  p_slot2_needs_slot1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sl2_vld_o |-> tx_sl1_vld_o);
  p_slot_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sl1_vld_o || tx_sl2_vld_o) |-> tx_frame_o);
  p_busy_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sl1_vld_o |-> !b1_q);
  p_gate_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !ctrl_i.tx1_en) |=> !tx_sl1_vld_o);
endmodule

// File: rtl/ac97_stat_rx.sv
module ac97_stat_rx
  import ac97_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctrl_t              ctrl_i,
  input  logic               rx_frame_i,
  input  logic [CODEC_W-1:0] rx_codec_i,
  input  logic               rx_sl1_vld_i,
  input  logic [SLOT_W-1:0]  rx_slot1_i,
  input  logic               rx_sl2_vld_i,
  input  logic [SLOT_W-1:0]  rx_slot2_i,
  input  logic               rd_rx1_i,
  input  logic               rd_rx2_i,
  input  logic               rd_res_i,
  input  logic               rd_load_i,
  input  logic [CADDR_W-1:0] rd_addr_i,
  output logic [SLOT_W-1:0]  rx1_word_o,
  output logic [SLOT_W-1:0]  rx2_word_o,
  output logic               rx1_vld_o,
  output logic               rx2_vld_o,
  output logic [SLOT_W-1:0]  result_o
);
  logic [SLOT_W-1:0]  r1_q, r1_d, r2_q, r2_d;
  logic               v1_q, v1_d, v2_q, v2_d;
  logic [CADDR_W-1:0] ra_q, ra_d;
  logic               ours, cap1, cap2, match;

  always_comb begin
    ours = rx_frame_i && (rx_codec_i == ctrl_i.codec);
    cap1 = ours && rx_sl1_vld_i && ctrl_i.rx1_en;
    cap2 = ours && rx_sl2_vld_i && ctrl_i.rx2_en;
    r1_d = cap1 ? rx_slot1_i : r1_q;
    r2_d = cap2 ? rx_slot2_i : r2_q;
    v1_d = v1_q;
    v2_d = v2_q;
    if (rd_rx1_i || rd_res_i) v1_d = 1'b0;
    if (rd_rx2_i || rd_res_i) v2_d = 1'b0;
    if (cap1) v1_d = 1'b1;
    if (cap2) v2_d = 1'b1;
    ra_d = rd_load_i ? rd_addr_i : ra_q;
    match = (r1_q[CADDR_LSB +: CADDR_W] == ra_q);
    result_o = '0;
    if (match) result_o[CDATA_W-1:0] = r2_q[CDATA_LSB +: CDATA_W];
    else       result_o[CDATA_W-1:0] = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q <= '0;
      r2_q <= '0;
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      ra_q <= '0;
    end else begin
      r1_q <= r1_d;
      r2_q <= r2_d;
      v1_q <= v1_d;
      v2_q <= v2_d;
      ra_q <= ra_d;
    end
  end

  assign rx1_word_o = r1_q;
  assign rx2_word_o = r2_q;
  assign rx1_vld_o  = v1_q;
  assign rx2_vld_o  = v2_q;

  p_capture_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame_i && rx_codec_i == ctrl_i.codec && rx_sl1_vld_i && ctrl_i.rx1_en)
      |=> (v1_q && r1_q == $past(rx_slot1_i)));
  p_rx_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i.rx2_en || rx_codec_i != ctrl_i.codec) |=> $stable(r2_q));
  p_res_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_res_i && !rx_frame_i) |=> (!v1_q && !v2_q));
endmodule

// File: rtl/ac97_cmd_port.sv
module ac97_cmd_port
  import ac97_cmd_pkg::*;
#(
  parameter int FRAME_LEN = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel_i,
  input  logic         bus_we_i,
  input  logic [2:0]   bus_addr_i,
  input  logic [19:0]  bus_wdata_i,
  output logic [19:0]  bus_rdata_o,
  output logic         tx_frame_o,
  output logic [1:0]   tx_codec_o,
  output logic         tx_sl1_vld_o,
  output logic [19:0]  tx_sl1_o,
  output logic         tx_sl2_vld_o,
  output logic [19:0]  tx_sl2_o,
  input  logic         rx_frame_i,
  input  logic [1:0]   rx_codec_i,
  input  logic         rx_sl1_vld_i,
  input  logic [19:0]  rx_slot1_i,
  input  logic         rx_sl2_vld_i,
  input  logic [19:0]  rx_slot2_i
);
  localparam int CTRL_W  = $bits(ctrl_t);
  localparam int ERR_BIT = 4;

  ctrl_t ctrl_q, ctrl_d;
  logic  err_q, err_d;
  logic  wr, rd, wr_ctrl, wr_tx1, wr_tx2, wr_stat, rd_rx1, rd_rx2, rd_res;
  logic  fire, drop, rd_load, b1, b2, rv1, rv2;
  logic [CADDR_W-1:0] rd_addr;
  logic [SLOT_W-1:0]  tx1_w, tx2_w, rx1_w, rx2_w, res_w;

  always_comb begin
    wr      = bus_sel_i && bus_we_i;
    rd      = bus_sel_i && !bus_we_i;
    wr_ctrl = wr && (bus_addr_i == RA_CTRL);
    wr_tx1  = wr && (bus_addr_i == RA_TX1);
    wr_tx2  = wr && (bus_addr_i == RA_TX2);
    wr_stat = wr && (bus_addr_i == RA_STAT);
    rd_rx1  = rd && (bus_addr_i == RA_RX1);
    rd_rx2  = rd && (bus_addr_i == RA_RX2);
    rd_res  = rd && (bus_addr_i == RA_RES);
    ctrl_d  = wr_ctrl ? ctrl_t'(bus_wdata_i[CTRL_W-1:0]) : ctrl_q;
    err_d   = err_q;
    if (wr_stat && bus_wdata_i[ERR_BIT]) err_d = 1'b0;
    if (drop) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      err_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      err_q  <= err_d;
    end
  end

  ac97_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .fire_o(fire));

  ac97_cmd_tx u_tx (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .ctrl_i(ctrl_q),
    .wr_tx1_i(wr_tx1), .wr_tx2_i(wr_tx2), .wdata_i(bus_wdata_i),
    .tx1_busy_o(b1), .tx2_busy_o(b2), .tx1_word_o(tx1_w), .tx2_word_o(tx2_w),
    .drop_o(drop), .rd_load_o(rd_load), .rd_addr_o(rd_addr),
    .tx_frame_o(tx_frame_o), .tx_codec_o(tx_codec_o),
    .tx_sl1_vld_o(tx_sl1_vld_o), .tx_sl1_o(tx_sl1_o),
    .tx_sl2_vld_o(tx_sl2_vld_o), .tx_sl2_o(tx_sl2_o));

  ac97_stat_rx u_rx (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_q),
    .rx_frame_i(rx_frame_i), .rx_codec_i(rx_codec_i),
    .rx_sl1_vld_i(rx_sl1_vld_i), .rx_slot1_i(rx_slot1_i),
    .rx_sl2_vld_i(rx_sl2_vld_i), .rx_slot2_i(rx_slot2_i),
    .rd_rx1_i(rd_rx1), .rd_rx2_i(rd_rx2), .rd_res_i(rd_res),
    .rd_load_i(rd_load), .rd_addr_i(rd_addr),
    .rx1_word_o(rx1_w), .rx2_word_o(rx2_w),
    .rx1_vld_o(rv1), .rx2_vld_o(rv2), .result_o(res_w));

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      RA_CTRL: bus_rdata_o[CTRL_W-1:0] = ctrl_q;
      RA_TX1:  bus_rdata_o = tx1_w;
      RA_TX2:  bus_rdata_o = tx2_w;
      RA_RX1:  bus_rdata_o = rx1_w;
      RA_RX2:  bus_rdata_o = rx2_w;
      RA_STAT: bus_rdata_o[ERR_BIT:0] = {err_q, rv2, rv1, b2, b1};
      RA_RES:  bus_rdata_o = res_w;
      default: bus_rdata_o = '0;
    endcase
  end

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(wr_stat && bus_wdata_i[ERR_BIT])) |=> err_q);
  p_codec_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr_ctrl) |=> (tx_codec_o == ctrl_q.codec));
endmodule

// File: tb/ac97_cmd_port_tb.sv
module ac97_cmd_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FL = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [19:0] bus_wdata = '0, bus_rdata;
  logic tx_frame, tx_sl1_vld, tx_sl2_vld;
  logic [1:0] tx_codec;
  logic [19:0] tx_sl1, tx_sl2;
  logic rx_frame = 1'b0, rx_v1 = 1'b0, rx_v2 = 1'b0;
  logic [1:0] rx_codec = '0;
  logic [19:0] rx_s1 = '0, rx_s2 = '0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ac97_cmd_port #(.FRAME_LEN(FL)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .tx_frame_o(tx_frame), .tx_codec_o(tx_codec),
    .tx_sl1_vld_o(tx_sl1_vld), .tx_sl1_o(tx_sl1),
    .tx_sl2_vld_o(tx_sl2_vld), .tx_sl2_o(tx_sl2),
    .rx_frame_i(rx_frame), .rx_codec_i(rx_codec),
    .rx_sl1_vld_i(rx_v1), .rx_slot1_i(rx_s1),
    .rx_sl2_vld_i(rx_v2), .rx_slot2_i(rx_s2));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [19:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [19:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic next_frame();
    @(negedge clk);
    while (!tx_frame) @(negedge clk);
  endtask

  task automatic rx_drive(input logic [1:0] c, input logic v1, input logic [19:0] s1,
                          input logic v2, input logic [19:0] s2);
    rx_frame = 1'b1; rx_codec = c; rx_v1 = v1; rx_s1 = s1; rx_v2 = v2; rx_s2 = s2;
    @(negedge clk);
    rx_frame = 1'b0; rx_v1 = 1'b0; rx_v2 = 1'b0;
  endtask

  task automatic t_reset();
    logic [19:0] d;
    rd(3'd5, d); chk("R1 status", d, 0);
    rd(3'd0, d); chk("R1 ctrl", d, 0);
    rd(3'd1, d); chk("R1 tx1", d, 0);
    chk("R1 outputs", {tx_frame, tx_sl1_vld, tx_sl2_vld}, 0);
  endtask

  task automatic t_period();
    int n = 0;
    next_frame();
    do begin @(negedge clk); n++; end while (!tx_frame);
    chk("R2 period", n, FL);
    @(negedge clk);
    chk("R2 one-cycle pulse", tx_frame, 0);
  endtask

  task automatic t_write_cmd();
    logic [19:0] d;
    wr(3'd0, 20'h0002F);
    rd(3'd0, d); chk("R11 ctrl readback", d, 20'h2F);
    wr(3'd2, 20'hABCD0);
    wr(3'd1, 20'h15000);
    rd(3'd5, d); chk("R4 busy set", d, 20'h3);
    next_frame();
    chk("R3 both slots", {tx_sl1_vld, tx_sl2_vld}, 2'b11);
    chk("R3 slot1 word", tx_sl1, 20'h15000);
    chk("R3 slot2 word", tx_sl2, 20'hABCD0);
    chk("R11 codec out", tx_codec, 2);
    rd(3'd5, d); chk("R4 busy cleared", d, 0);
  endtask

  task automatic t_busy_gate();
    logic [19:0] d;
    wr(3'd0, 20'h0002E);
    wr(3'd1, 20'h15000);
    wr(3'd1, 20'h16000);
    rd(3'd5, d); chk("R6 error set", d, 20'h11);
    rd(3'd1, d); chk("R6 write ignored", d, 20'h15000);
    next_frame();
    chk("R7 slot1 held", tx_sl1_vld, 0);
    rd(3'd5, d); chk("R7 still busy", d, 20'h11);
    wr(3'd0, 20'h0002F);
    next_frame();
    chk("R7 sent after enable", {tx_sl1_vld, tx_sl2_vld}, 2'b10);
    chk("R7 slot1 word", tx_sl1, 20'h15000);
    rd(3'd5, d); chk("R6 error sticky", d, 20'h10);
    wr(3'd5, 20'h00010);
    rd(3'd5, d); chk("R6 error cleared", d, 0);
  endtask

  task automatic t_coincide();
    logic [19:0] d;
    next_frame();
    repeat (FL - 1) @(negedge clk);
    wr(3'd1, 20'h17000);
    chk("R5 frame at boundary", tx_frame, 1);
    chk("R5 not in this frame", tx_sl1_vld, 0);
    rd(3'd5, d); chk("R5 still busy", d, 20'h1);
    next_frame();
    chk("R5 sent next frame", tx_sl1_vld, 1);
    chk("R5 slot1 word", tx_sl1, 20'h17000);
  endtask

  task automatic t_read_flow();
    logic [19:0] d;
    wr(3'd1, 20'hA6000);
    next_frame();
    chk("R3 read flag word", {tx_sl1_vld, tx_sl2_vld, tx_sl1}, {2'b10, 20'hA6000});
    rx_drive(2, 1, 20'h26000, 1, 20'h12340);
    rd(3'd5, d); chk("R8 both valid", d, 20'h0C);
    rd(3'd6, d); chk("R10 match result", d, 20'h01234);
    rd(3'd5, d); chk("R10 result clears", d, 0);
    rx_drive(2, 1, 20'h27000, 1, 20'h55550);
    rd(3'd6, d); chk("R10 mismatch result", d, 20'h0FFFF);
    rx_drive(2, 1, 20'h26000, 1, 20'h00010);
    rd(3'd3, d); chk("R8 rx1 word", d, 20'h26000);
    rd(3'd5, d); chk("R8 only slot1 cleared", d, 20'h08);
    rd(3'd4, d); chk("R8 rx2 word", d, 20'h00010);
    rd(3'd5, d); chk("R8 slot2 cleared", d, 0);
  endtask

  task automatic t_rx_gate();
    logic [19:0] d;
    rx_drive(1, 1, 20'h31000, 1, 20'h77770);
    rd(3'd5, d); chk("R9 codec mismatch", d, 0);
    rd(3'd3, d); chk("R9 rx1 unchanged", d, 20'h26000);
    wr(3'd0, 20'h00027);
    rx_drive(2, 1, 20'h32000, 1, 20'h88880);
    rd(3'd5, d); chk("R9 rx2 disabled", d, 20'h04);
    rd(3'd4, d); chk("R9 rx2 unchanged", d, 20'h00010);
    rd(3'd3, d); chk("R8 rx1 enabled capture", d, 20'h32000);
    wr(3'd0, 20'h0002F);
  endtask

  task automatic t_read_vs_capture();
    logic [19:0] d;
    rx_drive(2, 1, 20'h26000, 0, 20'h0);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 3'd3;
    rx_frame = 1'b1; rx_codec = 2; rx_v1 = 1'b1; rx_s1 = 20'h31000; rx_v2 = 1'b0;
    #1 d = bus_rdata;
    chk("R8 read returns old word", d, 20'h26000);
    @(negedge clk);
    bus_sel = 1'b0; rx_frame = 1'b0; rx_v1 = 1'b0;
    rd(3'd5, d); chk("R8 capture beats clear", d, 20'h04);
    rd(3'd3, d); chk("R8 new word kept", d, 20'h31000);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_period();
    t_write_cmd();
    t_busy_gate();
    t_coincide();
    t_read_flow();
    t_rx_gate();
    t_read_vs_capture();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule